// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches sixteen external interrupt pins and turns their activity into three interrupt requests for a parent vector controller. Each pin first passes through a two-flop synchroniser. A detector then turns the synchronised level, or its change since the previous cycle, into a one-cycle capture event. The trigger kind is chosen per pair of lines. Captured events are held in a pending register until software clears them. A per-line mask decides which pending lines may reach the outputs.

Software reaches three registers through a small register bus made of an address, a write strobe, write data and combinational read data. The trigger register holds eight 3-bit codes, one for each pair of lines. Line n uses the code at bit offset (n/2)*4, so lines 2k and 2k+1 share a code, and bit 3 of every nibble is never stored. The mask register holds one bit per line. The pending register reports the raw captured bits and is cleared by writing ones. The sixteen qualified lines are merged onto three outputs of unequal width.

Top module: `xirq_grouper`

## Requirements
- R1: While reset is asserted, the trigger register reads 0x00000000, the mask register reads 0x0000FFFF, the pending register reads 0x00000000 and all group outputs are low.
- R2: The trigger register is at address 0. Line n takes its code from bits [(n/2)*4+2 : (n/2)*4]. Bit 3 of each nibble is not stored and reads 0, so writing 0xFFFFFFFF reads back as 0x77777777.
- R3: Code 000 captures while the synchronised pin is low and code 001 captures while it is high. Capture repeats on every cycle the level holds, so a clear takes effect only once the pin is inactive.
- R4: Code 010 captures on a falling edge, code 100 on a rising edge and code 110 on either edge. The edge is found by comparing the synchronised value with its value one cycle earlier.
- R5: Codes 011, 101 and 111 never capture, whatever the pin does.
- R6: The mask register is at address 1, with bit n for line n. A 1 blocks the line from the group outputs and a 0 lets it through. The pending register still shows masked lines.
- R7: The pending register is at address 2. Writing a 1 to bit n clears that bit, and writing a 0 leaves it unchanged.
- R8: When a capture and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Output bit 0 is high when any of lines 0 to 3 is both pending and unmasked. Output bit 1 does the same for lines 4 to 11, and output bit 2 for lines 12 to 15.
- R10: After a pin changes between clock edges, its pending bit reads 1 after the third rising edge that follows the change, and still reads 0 after the second.
- R11: Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 16 | External interrupt pins, asynchronous |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_grp | output | 3 | Grouped interrupt requests |

## Verification
The main sweep visits all sixteen lines and all eight trigger codes. For each pair it holds the pin low, raises it, and lowers it again, with a clear after each step. This shows level capture apart from edge capture, rising edges apart from falling ones, and valid codes apart from disabled ones. Leaving the partner line masked while it shares the same code shows that the pair shares one field, and that a masked bit appears in the pending read but not on the outputs. Directed patterns then cover partial clears against each group boundary, a clear that lands on the same cycle as a capture, the exact synchroniser latency, and the unused address.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [2:0] {
        TRG_LOW  = 3'b000,
        TRG_HIGH = 3'b001,
        TRG_FALL = 3'b010,
        TRG_RISE = 3'b100,
        TRG_BOTH = 3'b110
    } trig_e;

    localparam logic [1:0] REG_CFG  = 2'd0;
    localparam logic [1:0] REG_MASK = 2'd1;
    localparam logic [1:0] REG_PEND = 2'd2;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prv
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
(
    input  logic [2:0] code,
    input  logic       cur,
    input  logic       prv,
    output logic       evt
);
    always_comb begin
        evt = 1'b0;
        case (code)
            TRG_LOW:  evt = !cur;
            TRG_HIGH: evt = cur;
            TRG_FALL: evt = prv && !cur;
            TRG_RISE: evt = !prv && cur;
            TRG_BOTH: evt = prv ^ cur;
            default:  evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES    = 16,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 2,
    parameter int FIELD_STRIDE = 4,
    parameter int FIELD_W      = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_we,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic [NUM_LINES-1:0]            evt,
    output logic [(NUM_LINES/2)*FIELD_W-1:0] cfg_codes,
    output logic [NUM_LINES-1:0]            mask,
    output logic [NUM_LINES-1:0]            pend
);
    localparam int NUM_FIELDS = NUM_LINES / 2;
    localparam int CFG_USED   = NUM_FIELDS * FIELD_STRIDE;

    logic [FIELD_W-1:0]   cfg_q [NUM_FIELDS];
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] clr_vec;
    logic [DATA_W-1:0]    cfg_rd;
    logic                 wr_cfg;
    logic                 wr_mask;
    logic                 wr_pend;

    assign wr_cfg  = bus_we && (bus_addr == ADDR_W'(REG_CFG));
    assign wr_mask = bus_we && (bus_addr == ADDR_W'(REG_MASK));
    assign wr_pend = bus_we && (bus_addr == ADDR_W'(REG_PEND));
    assign clr_vec = wr_pend ? bus_wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FIELDS; f++) cfg_q[f] <= '0;
            mask_q <= '1;
        end else begin
            if (wr_cfg) begin
                for (int f = 0; f < NUM_FIELDS; f++)
                    cfg_q[f] <= bus_wdata[f*FIELD_STRIDE +: FIELD_W];
            end
            if (wr_mask) mask_q <= bus_wdata[NUM_LINES-1:0];
        end
    end

    // Capture has priority over a clear landing in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | evt;
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign cfg_rd[f*FIELD_STRIDE +: FIELD_STRIDE] =
            {{(FIELD_STRIDE-FIELD_W){1'b0}}, cfg_q[f]};
        assign cfg_codes[f*FIELD_W +: FIELD_W] = cfg_q[f];
    end
    if (CFG_USED < DATA_W) begin : g_cfg_pad
        assign cfg_rd[DATA_W-1:CFG_USED] = '0;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_CFG):  bus_rdata = cfg_rd;
            ADDR_W'(REG_MASK): bus_rdata = DATA_W'(mask_q);
            ADDR_W'(REG_PEND): bus_rdata = DATA_W'(pend_q);
            default:           bus_rdata = '0;
        endcase
    end

    assign mask = mask_q;
    assign pend = pend_q;

    // R6: the mask changes only on a write to its address
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/xirq_grouper.sv
module xirq_grouper
    import xirq_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int GRP1_START  = 4,
    parameter int GRP2_START  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [2:0]           irq_grp
);
    localparam int FIELD_W    = 3;
    localparam int NUM_FIELDS = NUM_LINES / 2;
    localparam int NUM_GRPS   = 3;

    logic [NUM_LINES-1:0]          sync_cur;
    logic [NUM_LINES-1:0]          sync_prv;
    logic [NUM_LINES-1:0]          evt;
    logic [NUM_LINES-1:0]          mask;
    logic [NUM_LINES-1:0]          pend;
    logic [NUM_LINES-1:0]          live;
    logic [NUM_FIELDS*FIELD_W-1:0] cfg_codes;
    logic [FIELD_W-1:0]            line_code [NUM_LINES];

    xirq_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .cur   (sync_cur),
        .prv   (sync_prv)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign line_code[n] = cfg_codes[(n/2)*FIELD_W +: FIELD_W];

        xirq_detect u_det (
            .code (line_code[n]),
            .cur  (sync_cur[n]),
            .prv  (sync_prv[n]),
            .evt  (evt[n])
        );

        // R5: disabled codes never capture
        a_r5_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (line_code[n] == 3'b011 || line_code[n] == 3'b101 ||
             line_code[n] == 3'b111) |-> !evt[n]);

        // R3: an active high level keeps the pending bit set
        a_r3_level_high: assert property (@(posedge clk) disable iff (!rst_n)
            (line_code[n] == TRG_HIGH && sync_cur[n]) |=> pend[n]);
    end

    xirq_regs #(
        .NUM_LINES    (NUM_LINES),
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .FIELD_STRIDE (4),
        .FIELD_W      (FIELD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .cfg_codes (cfg_codes),
        .mask      (mask),
        .pend      (pend)
    );

    assign live = pend & ~mask;

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        localparam int LO = (g == 0) ? 0 : (g == 1) ? GRP1_START : GRP2_START;
        localparam int HI = (g == 0) ? GRP1_START - 1 :
                            (g == 1) ? GRP2_START - 1 : NUM_LINES - 1;
        assign irq_grp[g] = |live[HI:LO];
    end

    // R8: a capture always survives a same-cycle clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(evt)) == $past(evt)));

    // R7: written ones are cleared unless a capture coincides
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_PEND)) |=>
        ((pend & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(evt)) == '0));

    // R9: no live line means no request
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == '0) |-> (irq_grp == 3'b000));
endmodule

// File: tb/xirq_grouper_test.sv
module xirq_grouper_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pin_in;
    logic [1:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_grp;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xirq_grouper uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_grp   (irq_grp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] grp_of(input int line);
        if (line < 4)       return 3'b001;
        else if (line < 12) return 3'b010;
        else                return 3'b100;
    endfunction

    task automatic step_chk(input string req, input int line, input int partner,
                            input bit exp_line, input bit exp_part);
        logic [31:0] v;
        logic [31:0] e;
        e = 32'(exp_line) << line | 32'(exp_part) << partner;
        rd(2'd2, v);
        chk(req, v, e);
        chk("R9 group", {29'd0, irq_grp}, exp_line ? {29'd0, grp_of(line)} : 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; pin_in = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        idle(3);
        // R1 reset state
        rd(2'd0, v); chk("R1 cfg", v, 32'h0);
        rd(2'd1, v); chk("R1 mask", v, 32'h0000FFFF);
        rd(2'd2, v); chk("R1 pend", v, 32'h0);
        chk("R1 irq", {29'd0, irq_grp}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2 field layout
        wr(2'd0, 32'hFFFFFFFF); rd(2'd0, v); chk("R2 unused bits", v, 32'h77777777);
        wr(2'd0, 32'h1234567F); rd(2'd0, v); chk("R2 pattern", v, 32'h12345677);
        // R11 unused address
        wr(2'd3, 32'hAAAAAAAA); rd(2'd3, v); chk("R11 read", v, 32'h0);
        rd(2'd0, v); chk("R11 cfg kept", v, 32'h12345677);
        rd(2'd1, v); chk("R11 mask kept", v, 32'h0000FFFF);
        // R6 mask read/write
        wr(2'd1, 32'hDEADA5A5); rd(2'd1, v); chk("R6 mask rw", v, 32'h0000A5A5);

        // sweep over every line and every code
        for (int line = 0; line < 16; line++) begin
            for (int code = 0; code < 8; code++) begin
                int    sh;
                int    partner;
                bit    lowc, highc, fallc, risec, bothc;
                string tag;
                sh      = (line / 2) * 4;
                partner = line ^ 1;
                lowc  = (code == 0); highc = (code == 1); fallc = (code == 2);
                risec = (code == 4); bothc = (code == 6);
                tag = (code <= 1) ? "R3 level" :
                      (code == 2 || code == 4 || code == 6) ? "R4 edge" : "R5 off";
                pin_in = '0;
                wr(2'd0, (32'h77777777 & ~(32'h7 << sh)) | (32'(code) << sh));
                wr(2'd1, 32'(~(16'h1 << line)));
                idle(5);
                wr(2'd2, 32'hFFFF);
                step_chk(tag, line, partner, lowc, lowc);
                pin_in[line] = 1'b1;
                idle(5);
                step_chk(tag, line, partner, lowc | highc | risec | bothc, lowc);
                wr(2'd2, 32'hFFFF);
                step_chk(tag, line, partner, highc, lowc);
                pin_in[line] = 1'b0;
                idle(5);
                step_chk(tag, line, partner, lowc | highc | fallc | bothc, lowc);
                wr(2'd2, 32'hFFFF);
                step_chk(tag, line, partner, lowc, lowc);
            end
        end

        // R6 masked lines stay visible but do not request
        wr(2'd0, 32'h0); wr(2'd1, 32'hFFFF); idle(5);
        rd(2'd2, v); chk("R6 masked visible", v, 32'h0000FFFF);
        chk("R6 masked quiet", {29'd0, irq_grp}, 32'd0);

        // R7 write-one-to-clear, with R9 group boundaries
        wr(2'd0, 32'h44444444); wr(2'd1, 32'h0); wr(2'd2, 32'hFFFF);
        pin_in = 16'hFFFF; idle(5);
        rd(2'd2, v); chk("R7 all rise", v, 32'h0000FFFF);
        wr(2'd2, 32'h0); rd(2'd2, v); chk("R7 zero write", v, 32'h0000FFFF);
        wr(2'd2, 32'h00F0); rd(2'd2, v); chk("R7 partial", v, 32'h0000FF0F);
        chk("R9 three groups", {29'd0, irq_grp}, 32'd7);
        wr(2'd2, 32'h0F0F); rd(2'd2, v); chk("R7 partial2", v, 32'h0000F000);
        chk("R9 top group", {29'd0, irq_grp}, 32'd4);

        // R10 latency
        pin_in = '0; idle(5); wr(2'd2, 32'hFFFF);
        pin_in[5] = 1'b1;
        @(negedge clk); rd(2'd2, v); chk("R10 edge1", v, 32'h0);
        @(negedge clk); rd(2'd2, v); chk("R10 edge2", v, 32'h0);
        @(negedge clk); rd(2'd2, v); chk("R10 edge3", v, 32'h00000020);

        // R8 capture against a same-cycle clear
        wr(2'd0, 32'h66666666); pin_in = '0; idle(5); wr(2'd2, 32'hFFFF);
        pin_in[9] = 1'b1; idle(5);
        rd(2'd2, v); chk("R8 setup", v, 32'h00000200);
        pin_in[9] = 1'b0; idle(2);
        wr(2'd2, 32'h0200);
        rd(2'd2, v); chk("R8 event wins", v, 32'h00000200);
        wr(2'd2, 32'h0200);
        rd(2'd2, v); chk("R8 later clear", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule